// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire bus slave that exposes a small bank of 8-bit configuration registers to a bus master. It oversamples the clock and data lines with the system clock, finds start and stop conditions, matches its own 7-bit address, and decodes a command byte. The command byte picks one of two access styles. Indexed access reaches any single register, or a pair of registers, at an offset the command carries. Block access always begins at register zero and carries an explicit byte count.

Reads use a write-addressed command phase, then a repeated start with the read address. The slave shifts out the register data and stops driving as soon as the master refuses a byte. The data line is open-drain. The block models it as an input plus a pull-low enable. A second, synchronous read port lets the rest of the chip observe the register contents.

Top module: `smb_regfile_slave`

## Requirements
- R1: After reset the slave does not pull the data line low, and every register reads 0x00.
- R2: Only a first byte whose upper seven bits equal SLAVE_ADDR is acknowledged. On any other address the slave never pulls the data line, and the transfer changes no register until the next start.
- R3: A command byte with bit 7 = 1 selects indexed access at offset bits 6:0. In a write, the data byte that follows the command is acknowledged and stored at that offset.
- R4: After an indexed command, a repeated start with the read bit (bit 0 = 1) returns the register at the offset. Each byte the master acknowledges advances the offset by one, so a word moves the low byte (offset) first and then the high byte (offset+1). The same ascending order applies to writes.
- R5: A command byte of 0x00 selects block access. In a block write, the next byte is a count that is acknowledged but not stored. The data bytes after it land at offsets 0, 1, 2 and upward.
- R6: A block read (command 0x00, repeated start, read address) returns first a count byte equal to NUM_REGS, then the registers from offset 0 upward.
- R7: Each byte is transferred most significant bit first in both directions.
- R8: A data byte written to an offset at or beyond NUM_REGS is acknowledged and discarded. No implemented register changes, and the offset does not wrap.
- R9: A start or stop condition in the middle of a byte abandons the transfer without writing a partial byte. A following transfer then works normally.
- R10: After the master answers a byte with a not-acknowledge, the slave keeps the data line released until the next start or stop.
- R11: The system read port returns the register at cfg_addr_i one clock after the address is applied, and 0x00 for addresses at or beyond NUM_REGS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull the data line low |
| cfg_addr_i | input | 8 | Register index for the system read port |
| cfg_data_o | output | 8 | Registered register contents for cfg_addr_i |

## Verification
The hardest situation to reach is a bus condition that lands inside a byte. A plain master task always finishes whole bytes, so the bench has a separate task that clocks out only a few bits of a data byte. It then issues either a stop or a fresh start, and afterwards checks through the system read port that the target register kept its old value. A second hard case is the master's not-acknowledge on the last byte of a block read. To reach it, the bench arranges for the next unread register to hold a value whose top bit is zero, so a slave that kept transmitting would visibly pull the line low. The bench then looks at the enable before it sends the stop.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_WCNT,
    PH_WDATA,
    PH_TX,
    PH_IGNORE
  } smb_phase_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s     = scl_sr[SYNC_STAGES-1];
  assign sda_s     = sda_sr[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int NUM_REGS  = 8,
  parameter int PTR_W     = 8,
  parameter int RD_PORTS  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [PTR_W-1:0]              wr_addr,
  input  logic [7:0]                    wr_data,
  input  logic [RD_PORTS-1:0][PTR_W-1:0] rd_addr,
  output logic [RD_PORTS-1:0][7:0]      rd_data
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(NUM_REGS);

  logic [7:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= 8'h00;
    end else if (wr_en && (wr_addr < LIMIT)) begin
      mem[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst)                    rd_data[p] <= 8'h00;
      else if (rd_addr[p] < LIMIT) rd_data[p] <= mem[rd_addr[p][IDX_W-1:0]];
      else                        rd_data[p] <= 8'h00;
    end
  end
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int         NUM_REGS   = 8,
  parameter int         PTR_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] rd_addr,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data
);
  localparam logic [PTR_W-1:0] LIMIT   = PTR_W'(NUM_REGS);
  localparam logic [7:0]       CNT_VAL = 8'(NUM_REGS);

  smb_phase_e       phase_q;
  logic [3:0]       bit_cnt_q;
  logic [6:0]       rx_q;
  logic [7:0]       tx_sh_q;
  logic             ack_pend_q, blk_q, tx_cnt_q;
  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       rx_next, tx_load;

  assign rx_next = {rx_q, sda_s};
  assign tx_load = tx_cnt_q ? CNT_VAL : rd_data;
  assign rd_addr = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;  bit_cnt_q <= '0; rx_q <= '0; tx_sh_q <= '0;
      ack_pend_q <= 1'b0;  blk_q <= 1'b0;  tx_cnt_q <= 1'b0; ptr_q <= '0;
      sda_oe <= 1'b0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase_q <= PH_ADDR; bit_cnt_q <= '0; ack_pend_q <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        phase_q <= PH_IDLE; bit_cnt_q <= '0; ack_pend_q <= 1'b0; sda_oe <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt_q != 4'd8) begin
            rx_q      <= rx_next[6:0];
            bit_cnt_q <= bit_cnt_q + 4'd1;
            if (bit_cnt_q == 4'd7) begin
              ack_pend_q <= 1'b0;
              case (phase_q)
                PH_ADDR: begin
                  if (rx_next[7:1] == SLAVE_ADDR) begin
                    ack_pend_q <= 1'b1;
                    if (rx_next[0]) begin
                      phase_q  <= PH_TX;
                      tx_cnt_q <= blk_q;
                    end else begin
                      phase_q <= PH_CMD;
                    end
                  end else begin
                    phase_q <= PH_IGNORE;
                  end
                end
                PH_CMD: begin
                  ack_pend_q <= 1'b1;
                  blk_q      <= ~rx_next[7];
                  ptr_q      <= rx_next[7] ? PTR_W'(rx_next[6:0]) : '0;
                  phase_q    <= rx_next[7] ? PH_WDATA : PH_WCNT;
                end
                PH_WCNT: begin
                  ack_pend_q <= 1'b1;
                  phase_q    <= PH_WDATA;
                end
                PH_WDATA: begin
                  ack_pend_q <= 1'b1;
                  ptr_q      <= ptr_q + 1'b1;
                  if (ptr_q < LIMIT) begin
                    wr_en   <= 1'b1;
                    wr_addr <= ptr_q;
                    wr_data <= rx_next;
                  end
                end
                default: ;
              endcase
            end
          end else begin
            bit_cnt_q  <= '0;
            ack_pend_q <= 1'b0;
            if (phase_q == PH_TX && !ack_pend_q) begin
              if (sda_s)         phase_q  <= PH_IGNORE;
              else if (tx_cnt_q) tx_cnt_q <= 1'b0;
              else               ptr_q    <= ptr_q + 1'b1;
            end
          end
        end else if (scl_fall) begin
          if (bit_cnt_q == 4'd8) begin
            sda_oe <= ack_pend_q;
          end else if (phase_q == PH_TX) begin
            if (bit_cnt_q == 4'd0) begin
              sda_oe  <= ~tx_load[7];
              tx_sh_q <= {tx_load[6:0], 1'b0};
            end else begin
              sda_oe  <= ~tx_sh_q[7];
              tx_sh_q <= {tx_sh_q[6:0], 1'b0};
            end
          end else begin
            sda_oe <= 1'b0;
          end
        end
      end
    end
  end

  // R8
  wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr < LIMIT));

  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IGNORE) |-> !sda_oe);

  // R9
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (!sda_oe && phase_q == PH_ADDR && bit_cnt_q == 4'd0));

  // R7
  bit_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt_q <= 4'd8);

  // R9
  write_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(scl_rise));
endmodule

// File: rtl/smb_regfile_slave.sv
module smb_regfile_slave #(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [7:0] cfg_addr_i,
  output logic [7:0] cfg_data_o
);
  localparam int PTR_W = 8;

  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr, bus_rd_addr;
  logic [7:0]       wr_data;
  logic [1:0][PTR_W-1:0] rd_addr;
  logic [1:0][7:0]       rd_data;

  assign rd_addr[0] = bus_rd_addr;
  assign rd_addr[1] = cfg_addr_i;
  assign cfg_data_o = rd_data[1];

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_proto_fsm #(.SLAVE_ADDR(SLAVE_ADDR), .NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data[0]),
    .rd_addr(bus_rd_addr), .sda_oe(sda_oe_o), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  smb_reg_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .RD_PORTS(2)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/smb_regfile_slave_bench.sv
module smb_regfile_slave_bench;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int T = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [7:0] cfg_addr = 8'h00;
  logic [7:0] cfg_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  smb_regfile_slave u_smb_regfile_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .cfg_addr_i(cfg_addr), .cfg_data_o(cfg_data)
  );

  task automatic hw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_is(int a, int exp, string req);
    cfg_addr = 8'(a);
    hw(1);
    check(cfg_data == 8'(exp), req, cfg_data, exp);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(T); scl_m = 1'b1; hw(T); sda_m = 1'b0; hw(T); scl_m = 1'b0; hw(T);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(T); scl_m = 1'b1; hw(T); sda_m = 1'b1; hw(T);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hw(T); scl_m = 1'b1; hw(T); scl_m = 1'b0; hw(2);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; hw(T); scl_m = 1'b1; hw(T);
    ack = !sda_line;
    scl_m = 1'b0; hw(T);
  endtask

  task automatic recv_byte(bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      hw(T); scl_m = 1'b1; hw(T); b = {b[6:0], sda_line}; scl_m = 1'b0;
    end
    hw(2); sda_m = nack; hw(T); scl_m = 1'b1; hw(T); scl_m = 1'b0; hw(2);
    sda_m = 1'b1; hw(T);
  endtask

  task automatic write_seq(logic [7:0] cmd, logic [7:0] d0, logic [7:0] d1, int n, string req);
    bit a;
    bus_start();
    send_byte({ADDR, 1'b0}, a); check(a, req, a, 1);
    send_byte(cmd, a);          check(a, req, a, 1);
    if (n > 0) begin send_byte(d0, a); check(a, req, a, 1); end
    if (n > 1) begin send_byte(d1, a); check(a, req, a, 1); end
    bus_stop();
  endtask

  task automatic t_reset();
    hw(3);
    check(sda_oe == 1'b0, "R1 line released", sda_oe, 0);
    for (int i = 0; i < 8; i++) reg_is(i, 0, "R1 reset value");
    reg_is(9, 0, "R11 out-of-range read");
  endtask

  task automatic t_byte_write();
    write_seq(8'h82, 8'hC4, 8'h00, 1, "R3 ack");
    reg_is(2, 8'hC4, "R3 R7 stored byte");
    reg_is(3, 0, "R3 neighbour untouched");
  endtask

  task automatic t_byte_read();
    bit a; logic [7:0] d;
    bus_start();
    send_byte({ADDR, 1'b0}, a); send_byte(8'h82, a);
    bus_start();
    send_byte({ADDR, 1'b1}, a); check(a, "R4 read addr ack", a, 1);
    recv_byte(1'b1, d); check(d == 8'hC4, "R4 R7 byte read", d, 8'hC4);
    check(sda_oe == 1'b0, "R10 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_word();
    bit a; logic [7:0] d;
    write_seq(8'h84, 8'h3A, 8'h5E, 2, "R4 word write ack");
    reg_is(4, 8'h3A, "R4 low byte");
    reg_is(5, 8'h5E, "R4 high byte");
    bus_start();
    send_byte({ADDR, 1'b0}, a); send_byte(8'h84, a);
    bus_start(); send_byte({ADDR, 1'b1}, a);
    recv_byte(1'b0, d); check(d == 8'h3A, "R4 word read low", d, 8'h3A);
    recv_byte(1'b1, d); check(d == 8'h5E, "R4 word read high", d, 8'h5E);
    bus_stop();
  endtask

  task automatic t_block_write();
    bit a;
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h00, a); check(a, "R5 block cmd ack", a, 1);
    send_byte(8'h03, a); check(a, "R5 count ack", a, 1);
    send_byte(8'h11, a); send_byte(8'h27, a); send_byte(8'h6C, a);
    check(a, "R5 data ack", a, 1);
    bus_stop();
    reg_is(0, 8'h11, "R5 offset 0");
    reg_is(1, 8'h27, "R5 offset 1");
    reg_is(2, 8'h6C, "R5 offset 2");
    reg_is(3, 8'h00, "R5 count not stored");
  endtask

  task automatic t_block_read();
    bit a; logic [7:0] d;
    bus_start();
    send_byte({ADDR, 1'b0}, a); send_byte(8'h00, a);
    bus_start(); send_byte({ADDR, 1'b1}, a);
    recv_byte(1'b0, d); check(d == 8'h08, "R6 count byte", d, 8'h08);
    recv_byte(1'b0, d); check(d == 8'h11, "R6 data 0", d, 8'h11);
    recv_byte(1'b0, d); check(d == 8'h27, "R6 data 1", d, 8'h27);
    recv_byte(1'b1, d); check(d == 8'h6C, "R6 data 2", d, 8'h6C);
    hw(T);
    check(sda_oe == 1'b0, "R10 no drive after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_bad_addr();
    bit a;
    bus_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, a); check(!a, "R2 foreign address", a, 0);
    send_byte(8'h80, a); check(!a, "R2 no ack on cmd", a, 0);
    send_byte(8'hFF, a);
    bus_stop();
    reg_is(0, 8'h11, "R2 register kept");
  endtask

  task automatic t_out_of_range();
    write_seq(8'h87, 8'h99, 8'hAA, 2, "R8 ack beyond range");
    reg_is(7, 8'h99, "R8 last register");
    reg_is(0, 8'h11, "R8 no wrap");
    write_seq(8'hD0, 8'h55, 8'h00, 1, "R8 far offset ack");
    for (int i = 3; i < 7; i++) if (i != 4 && i != 5) reg_is(i, 0, "R8 discarded");
  endtask

  task automatic t_abort();
    bit a;
    bus_start();
    send_byte({ADDR, 1'b0}, a); send_byte(8'h81, a);
    send_bits(8'hF0, 4);
    bus_stop();
    reg_is(1, 8'h27, "R9 stop mid byte");
    bus_start();
    send_byte({ADDR, 1'b0}, a); send_byte(8'h81, a);
    send_bits(8'h0F, 3);
    bus_start();
    send_byte({ADDR, 1'b0}, a); check(a, "R9 recovery ack", a, 1);
    send_byte(8'h81, a); send_byte(8'h42, a);
    bus_stop();
    reg_is(1, 8'h42, "R9 start mid byte then write");
  endtask

  initial begin
    hw(5);
    rst = 1'b0;
    t_reset();
    t_byte_write();
    t_byte_read();
    t_word();
    t_block_write();
    t_block_read();
    t_bad_addr();
    t_out_of_range();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule